// File: doc/BRIEF.md
# I2C Address-Match Wakeup Controller

This block keeps watch on the I2C bus while the host sits in a low-power stop state. Software arms it by setting a wake-enable bit in a small control register. Once armed, the block looks for a start condition. It then shifts in the first byte, which holds seven address bits and a direction bit, sent most significant bit first. If that byte carries the programmed own address, or the reserved extension-code prefix, the block does three things. It pulls SDA low to acknowledge. It holds SCL low after the acknowledge clock. It raises a single wakeup interrupt.

The SCL hold lasts until software clears the wake-enable bit. While the block is armed, stop-condition interrupts are suppressed. Arming is refused while the bus is in use. If software disarms the block without a prior wakeup, master start requests are refused until the bus shows the next start or stop condition. A ready flag tells the power controller when it may enter the stop state. The data phase, clock generation and analog filtering are handled elsewhere.

Top module: `i2c_wake_ctrl`

## Requirements
- R1: After reset the control register reads bits [0] and [4:3] as 0, and wake_irq_o, stop_irq_o, scl_hold_o and sda_ack_o are all low.
- R2: Writing 1 to control bit 0 (wake-enable) takes effect only when is_master_i is low, no start has been seen since the last stop, and no address hit is pending. Otherwise the write is ignored and bit 0 reads back 0.
- R3: stop_ready_o is low for the first three clocks after the write edge that arms the block, and high from the fourth clock on while the block stays armed.
- R4: When the block is armed and the first byte after a start has its upper seven bits equal to own_addr_i (bits sampled on SCL rising edges, MSB first), sda_ack_o is high during the ninth SCL clock. After the ninth falling edge, scl_hold_o goes high and wake_irq_o pulses for exactly one cycle.
- R5: A first byte whose upper five bits are 11110 is handled as in R4, whatever own_addr_i holds.
- R6: A first byte that matches neither the own address nor the extension code, or any byte received while the block is not armed, produces no acknowledge, no hold and no wakeup pulse.
- R7: scl_hold_o stays high until wake-enable is written to 0, and it falls at most two clocks after that write.
- R8: A stop condition (SDA rising while SCL is high) pulses stop_irq_o when stop_ie_i is high and the block is not armed. While the block is armed, no pulse is produced.
- R9: Writing wake-enable from 1 to 0 with no wakeup pulse since arming holds start_grant_o low, even while start_req_i is high, until a start or stop condition is detected on the bus. A disarm that follows a wakeup leaves start_grant_o equal to start_req_i.
- R10: Control bits [4:3] are written only while iface_en_i is 0. Bits [1] and [2] are read-only and show the synchronised SCL and SDA levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| own_addr_i | input | 7 | Programmed own address |
| iface_en_i | input | 1 | Serial interface enable |
| is_master_i | input | 1 | Interface currently acts as master |
| stop_ie_i | input | 1 | Stop-condition interrupt enable |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| start_req_i | input | 1 | Master start request |
| start_grant_o | output | 1 | Start request accepted |
| wake_irq_o | output | 1 | Wakeup interrupt pulse |
| stop_irq_o | output | 1 | Stop-condition interrupt pulse |
| scl_hold_o | output | 1 | Drive SCL low (wait) |
| sda_ack_o | output | 1 | Drive SDA low (acknowledge) |
| stop_ready_o | output | 1 | Stop state may be entered |

## Verification
The hardest state to reach is the master-start inhibit. It appears only when a disarm lands while no wakeup has happened, and it lasts until a bus condition clears it. The stimulus arms the block on an idle bus and disarms it at once. It then holds start_req_i high and checks that the grant stays low. Next it sends either a bare stop or a start sequence and checks that the grant returns. It also disarms after a real address-match wakeup, to show that the inhibit is not set in that case.

// File: rtl/i2c_wake_pkg.sv
`timescale 1ns/1ps
package i2c_wake_pkg;
  localparam int ADDR_W    = 7;
  localparam int BYTE_W    = ADDR_W + 1;
  localparam int EXT_W     = 5;
  localparam logic [EXT_W-1:0] EXT_PREFIX = 5'b11110;
  localparam int REG_W     = 8;
  localparam int WAKE_BIT  = 0;
  localparam int SCL_BIT   = 1;
  localparam int SDA_BIT   = 2;
  localparam int CFG_LO    = 3;
  localparam int CFG_W     = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_PEND, ST_ACK, ST_HOLD, ST_SKIP
  } addr_state_e;
endpackage

// File: rtl/i2c_bus_mon.sv
`timescale 1ns/1ps
module i2c_bus_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic busy_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= scl_i;
          sda_sync <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_o = scl_sync[SYNC_STAGES-1];
  assign sda_o = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_o;
      sda_q <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_o <= 1'b0;
    else if (start_o) busy_o <= 1'b1;
    else if (stop_o)  busy_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_addr_unit.sv
`timescale 1ns/1ps
module i2c_addr_unit
  import i2c_wake_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              armed_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              hit_o,
  output logic              wake_o,
  output logic              sda_ack_o,
  output logic              scl_hold_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  addr_state_e        state;
  logic [BYTE_W-1:0]  shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  byte_now;
  logic               own_hit, ext_hit;

  assign byte_now = {shreg[BYTE_W-2:0], sda_i};
  assign own_hit  = byte_now[BYTE_W-1:1] == own_addr_i;
  assign ext_hit  = byte_now[BYTE_W-1 -: EXT_W] == EXT_PREFIX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      hit_o   <= 1'b0;
      wake_o  <= 1'b0;
    end else begin
      wake_o <= 1'b0;
      if (start_i) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        hit_o   <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE;
        hit_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise_i) begin
            shreg   <= byte_now;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(BYTE_W-1)) begin
              if (armed_i && (own_hit || ext_hit)) begin
                state <= ST_ACK_PEND;
                hit_o <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ACK_PEND: if (scl_fall_i) state <= ST_ACK;
          ST_ACK: if (scl_fall_i) begin
            state  <= ST_HOLD;
            wake_o <= 1'b1;
          end
          ST_HOLD: if (!armed_i) state <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  assign sda_ack_o  = state == ST_ACK;
  assign scl_hold_o = state == ST_HOLD;
endmodule

// File: rtl/i2c_wake_regs.sv
`timescale 1ns/1ps
module i2c_wake_regs
  import i2c_wake_pkg::*;
#(
  parameter int READY_CLKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wake_wr_i,
  input  logic [CFG_W-1:0] cfg_wr_i,
  input  logic             iface_en_i,
  input  logic             is_master_i,
  input  logic             bus_busy_i,
  input  logic             hit_i,
  input  logic             wake_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             wake_en_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             ready_o,
  output logic             inhibit_o
);
  localparam int RC_W = $clog2(READY_CLKS + 1);

  logic [RC_W-1:0] rdy_cnt;
  logic            woke;
  logic            arm_ok;

  assign arm_ok = !is_master_i && !bus_busy_i && !hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_en_o <= 1'b0;
      cfg_o     <= '0;
      rdy_cnt   <= '0;
      woke      <= 1'b0;
      inhibit_o <= 1'b0;
    end else begin
      if (wake_en_o && rdy_cnt != RC_W'(READY_CLKS)) rdy_cnt <= rdy_cnt + 1'b1;
      if (wake_i) woke <= 1'b1;
      if (start_i || stop_i) inhibit_o <= 1'b0;
      if (we_i) begin
        if (!iface_en_i) cfg_o <= cfg_wr_i;
        if (wake_wr_i && !wake_en_o && arm_ok) begin
          wake_en_o <= 1'b1;
          rdy_cnt   <= '0;
          woke      <= 1'b0;
        end else if (!wake_wr_i && wake_en_o) begin
          wake_en_o <= 1'b0;
          if (!woke && !wake_i) inhibit_o <= 1'b1;
        end
      end
    end
  end

  assign ready_o = wake_en_o && rdy_cnt == RC_W'(READY_CLKS);
endmodule

// File: rtl/i2c_wake_ctrl.sv
`timescale 1ns/1ps
module i2c_wake_ctrl
  import i2c_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int READY_CLKS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              iface_en_i,
  input  logic              is_master_i,
  input  logic              stop_ie_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              start_req_i,
  output logic              start_grant_o,
  output logic              wake_irq_o,
  output logic              stop_irq_o,
  output logic              scl_hold_o,
  output logic              sda_ack_o,
  output logic              stop_ready_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, bus_busy;
  logic hit, wake_en, master_inhibit;
  logic [CFG_W-1:0] cfg;

  i2c_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det), .busy_o(bus_busy)
  );

  i2c_addr_unit u_addr (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .armed_i(wake_en), .own_addr_i,
    .hit_o(hit), .wake_o(wake_irq_o), .sda_ack_o, .scl_hold_o
  );

  i2c_wake_regs #(.READY_CLKS(READY_CLKS)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wake_wr_i(reg_wdata_i[WAKE_BIT]),
    .cfg_wr_i(reg_wdata_i[CFG_LO +: CFG_W]), .iface_en_i, .is_master_i,
    .bus_busy_i(bus_busy), .hit_i(hit), .wake_i(wake_irq_o),
    .start_i(start_det), .stop_i(stop_det), .wake_en_o(wake_en), .cfg_o(cfg),
    .ready_o(stop_ready_o), .inhibit_o(master_inhibit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stop_irq_o <= 1'b0;
    else         stop_irq_o <= stop_det && stop_ie_i && !wake_en;
  end

  always_comb begin
    reg_rdata_o                  = '0;
    reg_rdata_o[WAKE_BIT]        = wake_en;
    reg_rdata_o[SCL_BIT]         = scl_s;
    reg_rdata_o[SDA_BIT]         = sda_s;
    reg_rdata_o[CFG_LO +: CFG_W] = cfg;
  end

  assign start_grant_o = start_req_i && !master_inhibit;
endmodule

// File: rtl/i2c_wake_chk.sv
`timescale 1ns/1ps
module i2c_wake_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       wake_irq_o,
  input logic       stop_irq_o,
  input logic       scl_hold_o,
  input logic       stop_ready_o,
  input logic       master_inhibit
);
  assert_wake_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !wake_irq_o);

  assert_hold_with_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_hold_o) |-> wake_irq_o);

  assert_hold_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_rdata_o[0]) |=> !scl_hold_o);

  assert_stop_muted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_irq_o |-> $past(!reg_rdata_o[0]));

  assert_inhibit_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(master_inhibit) |-> $past(reg_we_i && !reg_wdata_i[0] && reg_rdata_o[0]));

  assert_ready_armed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ready_o |-> reg_rdata_o[0]);
endmodule

bind i2c_wake_ctrl i2c_wake_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .wake_irq_o(wake_irq_o), .stop_irq_o(stop_irq_o),
  .scl_hold_o(scl_hold_o), .stop_ready_o(stop_ready_o), .master_inhibit(master_inhibit)
);

// File: tb/test_i2c_wake_ctrl.sv
`timescale 1ns/1ps
module test_i2c_wake_ctrl;
  localparam int HALF = 4;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic iface_en = 1'b0, is_master = 1'b0, stop_ie = 1'b1;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic start_req = 1'b0;
  logic grant, wake_irq, stop_irq, scl_hold, sda_ack, ready;
  int total = 0, bad = 0, wake_cnt = 0, stop_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_wake_ctrl i_i2c_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .own_addr_i(OWN),
    .iface_en_i(iface_en), .is_master_i(is_master), .stop_ie_i(stop_ie),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .start_req_i(start_req), .start_grant_o(grant), .wake_irq_o(wake_irq),
    .stop_irq_o(stop_irq), .scl_hold_o(scl_hold), .sda_ack_o(sda_ack),
    .stop_ready_o(ready)
  );

  always @(negedge clk) begin
    if (wake_irq) wake_cnt++;
    if (stop_irq) stop_cnt++;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_start();
    scl = 1'b0; idle(HALF); sda = 1'b1; idle(HALF);
    scl = 1'b1; idle(HALF); sda = 1'b0; idle(HALF);
    scl = 1'b0; idle(HALF);
  endtask

  task automatic bus_stop();
    scl = 1'b0; idle(HALF); sda = 1'b0; idle(HALF);
    scl = 1'b1; idle(HALF); sda = 1'b1; idle(HALF);
  endtask

  task automatic bus_bit(logic b);
    sda = b; idle(HALF); scl = 1'b1; idle(HALF); scl = 1'b0; idle(HALF);
  endtask

  task automatic bus_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
  endtask

  // ninth clock: samples ack mid-high, returns hold level after the fall
  task automatic ninth(output logic ack, output logic hold);
    sda = 1'b1; idle(HALF); scl = 1'b1; idle(2);
    ack = sda_ack; idle(2); scl = 1'b0; idle(HALF);
    hold = scl_hold;
  endtask

  task automatic t_reset();
    check("R1 wake bit", rdata[0], 0);
    check("R1 cfg bits", rdata[4:3], 0);
    check("R1 outputs", {wake_irq, stop_irq, scl_hold, sda_ack}, 0);
  endtask

  task automatic t_ready();
    wr(8'h01);
    check("R2 arm on idle bus", rdata[0], 1);
    check("R3 not ready 1", ready, 0);
    idle(2);
    check("R3 not ready 3", ready, 0);
    idle(1);
    check("R3 ready 4", ready, 1);
    wr(8'h00);
    check("R3 ready off", ready, 0);
    bus_stop();
  endtask

  task automatic t_match();
    logic ack, hold;
    int w0;
    wr(8'h01);
    w0 = wake_cnt;
    bus_start();
    bus_byte({OWN, 1'b0});
    ninth(ack, hold);
    check("R4 ack", ack, 1);
    check("R4 hold", hold, 1);
    check("R4 one wake", wake_cnt - w0, 1);
    idle(20);
    check("R7 hold kept", scl_hold, 1);
    wr(8'h00);
    idle(1);
    check("R7 hold released", scl_hold, 0);
    start_req = 1'b1; idle(1);
    check("R9 no inhibit after wake", grant, 1);
    start_req = 1'b0;
    bus_stop();
  endtask

  task automatic t_ext();
    logic ack, hold;
    int w0;
    wr(8'h01);
    w0 = wake_cnt;
    bus_start();
    bus_byte(8'hF2);
    ninth(ack, hold);
    check("R5 ext ack", ack, 1);
    check("R5 ext hold", hold, 1);
    check("R5 ext wake", wake_cnt - w0, 1);
    wr(8'h00);
    bus_stop();
  endtask

  task automatic t_nomatch();
    logic ack, hold;
    int w0, s0;
    wr(8'h01);
    w0 = wake_cnt;
    bus_start();
    bus_byte({7'h2B, 1'b1});
    ninth(ack, hold);
    check("R6 no ack", ack, 0);
    check("R6 no hold", hold, 0);
    check("R6 no wake", wake_cnt - w0, 0);
    s0 = stop_cnt;
    bus_stop();
    check("R8 stop muted when armed", stop_cnt - s0, 0);
    wr(8'h00);
    bus_stop();
  endtask

  task automatic t_unarmed();
    logic ack, hold;
    int w0, s0;
    w0 = wake_cnt;
    bus_start();
    bus_byte({OWN, 1'b0});
    ninth(ack, hold);
    check("R6 unarmed ack", ack, 0);
    check("R6 unarmed hold", hold, 0);
    check("R6 unarmed wake", wake_cnt - w0, 0);
    s0 = stop_cnt;
    bus_stop();
    check("R8 stop irq when unarmed", stop_cnt - s0, 1);
  endtask

  task automatic t_arm_reject();
    bus_start();
    wr(8'h01);
    check("R2 busy bus rejects arm", rdata[0], 0);
    bus_stop();
    is_master = 1'b1;
    wr(8'h01);
    check("R2 master rejects arm", rdata[0], 0);
    is_master = 1'b0;
  endtask

  task automatic t_inhibit();
    wr(8'h01); wr(8'h00);
    start_req = 1'b1; idle(1);
    check("R9 start blocked", grant, 0);
    bus_stop();
    check("R9 stop clears block", grant, 1);
    start_req = 1'b0;
    wr(8'h01); wr(8'h00);
    start_req = 1'b1; idle(1);
    check("R9 start blocked again", grant, 0);
    bus_start();
    check("R9 start clears block", grant, 1);
    start_req = 1'b0;
    bus_stop();
  endtask

  task automatic t_cfg();
    iface_en = 1'b1;
    wr(8'h18);
    check("R10 cfg locked", rdata[4:3], 0);
    iface_en = 1'b0;
    wr(8'h18);
    check("R10 cfg written", rdata[4:3], 3);
    scl = 1'b0; sda = 1'b1; idle(HALF);
    wr(8'h06);
    check("R10 scl level", rdata[1], 0);
    check("R10 sda level", rdata[2], 1);
    sda = 1'b0; idle(HALF);
    check("R10 sda low", rdata[2], 0);
    bus_stop();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(4);
    t_ready();
    t_match();
    t_ext();
    t_nomatch();
    t_unarmed();
    t_arm_reject();
    t_inhibit();
    t_cfg();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule